// File: doc/BRIEF.md
# PWM Fault Shutdown and Pair Swap Stage

This block sits on the six PWM lines between a PWM generator and the output pins. It watches four active-high fault inputs. Each one passes through a two-stage synchronizer and can be enabled on its own. An enabled fault that is seen high latches a shutdown for that fault. The shutdown forces low every output named in that fault's 6-bit disable mask. It also sets a sticky status flag, which raises an interrupt request if that fault's interrupt enable is set. The shutdown itself does not depend on the interrupt enable.

Each fault releases its shutdown in one of two ways. In automatic mode, the outputs come back at the first PWM period boundary after the synchronized input is low. In manual mode, the outputs come back at a period boundary only when the input is low and software has also cleared the flag. Before the gating, an optional swap exchanges the two lines of a complementary pair. Swap control can be changed only after an enhancement-enable bit has been set.

All data moves as plain level signals, sampled every cycle, with no handshake and no back-pressure. The register port is a simple write strobe with a combinational read.

Top module: `pwm_fault_guard`

Register map (8-bit data, 3-bit address):

| Address | Contents |
|---|---|
| 0 | fault control |
| 1 | pin enables |
| 2 | status flags, bits 3:0; write 1 to clear |
| 3 | bit 7 is the enhancement enable, bits 2:0 are the swaps for pairs 0–2 |
| 4–7 | disable masks for faults 0–3, bits 5:0; bits 7:6 read 0 |

## Requirements
- R1: After reset every register reads 0, `fault_irq` is 0 and `pwm_out` equals `pwm_in`.
- R2: Address 0 holds, for fault i, the clearing-mode bit at position 2i+1 and the interrupt-enable bit at position 2i. It reads back as written. Addresses 4–7 read back the written bits 5:0, with bits 7:6 as 0.
- R3: Address 1 holds the pin enable of fault i at bit 2i. Bits 1, 3, 5 and 7 always read 0.
- R4: A fault with its pin enable set that is high on `fault_in` drives low the outputs in its mask. The outputs go low after the third rising clock edge once the input is high. The other outputs keep their values. A fault whose pin enable is 0 has no effect on the outputs or the flags.
- R5: The shutdown happens whatever the interrupt enable is. `fault_irq[i]` is high exactly while flag i and interrupt enable i are both set.
- R6: A detected fault sets flag i at address 2, bit i. The flag stays set until a 1 is written to that bit while the synchronized input is low. A clear written while the input is still high has no effect.
- R7: With mode bit 0 (manual), the shutdown is released only at a `period_edge` cycle in which the synchronized input is low and the flag is already clear.
- R8: With mode bit 1 (automatic), the shutdown is released at the first `period_edge` after the synchronized input is low, whatever the flag is. The flag stays set.
- R9: When several faults are latched, the disabled outputs are the union of their masks.
- R10: When swap bit p is set and `pair_comp[p]` is 1, outputs 2p and 2p+1 exchange their values. When `pair_comp[p]` is 0 the pair passes straight through.
- R11: Swap bits are written only if the stored enhancement-enable bit was already 1 before the write. A write that sets the enhancement bit leaves the swap bits unchanged.
- R12: Masks refer to the output lines after the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at `reg_addr` |
| pwm_in | input | 6 | PWM lines from the generator |
| pair_comp | input | 3 | Complementary-mode flag per pair |
| period_edge | input | 1 | One-cycle pulse at each PWM period boundary |
| fault_in | input | 4 | Asynchronous active-high fault inputs |
| pwm_out | output | 6 | Gated PWM lines to the pins |
| fault_irq | output | 4 | Interrupt request per fault |

## Verification
The assertions assume that `period_edge` is a single-cycle pulse. They also assume that a flag is lowered only by a write to the status address, and that the register inputs are stable around the clock edge. The stimulus drives every input on the falling edge and keeps `period_edge` to one cycle. It waits at least three cycles after each change of a fault input before it pulses a period boundary. This way the synchronized value is settled when the release is judged, and flag-clearing writes land in separate cycles from the boundary pulses.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned NUM_FAULT   = 4;
  localparam int unsigned NUM_PWM     = 6;
  localparam int unsigned NUM_PAIR    = NUM_PWM / 2;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL  = 3'd0,
    ADR_PINEN = 3'd1,
    ADR_STAT  = 3'd2,
    ADR_SWAP  = 3'd3,
    ADR_MASK0 = 3'd4,
    ADR_MASK1 = 3'd5,
    ADR_MASK2 = 3'd6,
    ADR_MASK3 = 3'd7
  } reg_addr_e;

  localparam int unsigned ENH_BIT = REG_W - 1;

  typedef logic [NUM_FAULT-1:0][NUM_PWM-1:0] mask_arr_t;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[k] <= '0;
      else        stage_q[k] <= stage_q[k-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pfg_regs.sv
module pfg_regs
  import pfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wen,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic [NUM_FAULT-1:0] flag,
  output logic [REG_W-1:0]     rdata,
  output logic [NUM_FAULT-1:0] mode_auto,
  output logic [NUM_FAULT-1:0] irq_en,
  output logic [NUM_FAULT-1:0] pin_en,
  output logic [NUM_FAULT-1:0] flag_clr,
  output logic [NUM_PAIR-1:0]  swap_en,
  output mask_arr_t            dis_mask
);
  localparam int unsigned MASK_SEL_W = $clog2(NUM_FAULT);

  logic enh_q;
  logic wr_ctrl, wr_pin, wr_stat, wr_swap, wr_mask;
  logic [MASK_SEL_W-1:0] mask_sel;
  logic [REG_W-1:0] ctrl_rd, pin_rd;

  assign wr_ctrl  = wen && (addr == ADR_CTRL);
  assign wr_pin   = wen && (addr == ADR_PINEN);
  assign wr_stat  = wen && (addr == ADR_STAT);
  assign wr_swap  = wen && (addr == ADR_SWAP);
  assign wr_mask  = wen && addr[ADDR_W-1];
  assign mask_sel = addr[MASK_SEL_W-1:0];

  // Per-fault fields: mode at odd position, enables at even position.
  for (genvar i = 0; i < NUM_FAULT; i++) begin : g_fault
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_auto[i] <= 1'b0;
        irq_en[i]    <= 1'b0;
        pin_en[i]    <= 1'b0;
        dis_mask[i]  <= '0;
      end else begin
        if (wr_ctrl) begin
          mode_auto[i] <= wdata[2*i+1];
          irq_en[i]    <= wdata[2*i];
        end
        if (wr_pin) pin_en[i] <= wdata[2*i];
        if (wr_mask && (mask_sel == MASK_SEL_W'(i))) dis_mask[i] <= wdata[NUM_PWM-1:0];
      end
    end
    assign flag_clr[i]       = wr_stat && wdata[i];
    assign ctrl_rd[2*i+1]    = mode_auto[i];
    assign ctrl_rd[2*i]      = irq_en[i];
    assign pin_rd[2*i+1]     = 1'b0;
    assign pin_rd[2*i]       = pin_en[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enh_q   <= 1'b0;
      swap_en <= '0;
    end else if (wr_swap) begin
      enh_q <= wdata[ENH_BIT];
      if (enh_q) swap_en <= wdata[NUM_PAIR-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_CTRL:  rdata = ctrl_rd;
      ADR_PINEN: rdata = pin_rd;
      ADR_STAT:  rdata[NUM_FAULT-1:0] = flag;
      ADR_SWAP: begin
        rdata[ENH_BIT]        = enh_q;
        rdata[NUM_PAIR-1:0]   = swap_en;
      end
      default:   rdata[NUM_PWM-1:0] = dis_mask[mask_sel];
    endcase
  end
endmodule

// File: rtl/pfg_fault_chan.sv
module pfg_fault_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_s,
  input  logic pin_en,
  input  logic mode_auto,
  input  logic flag_clr,
  input  logic period_edge,
  output logic flag,
  output logic act
);
  logic detect, release_ok;

  assign detect     = fault_s && pin_en;
  assign release_ok = period_edge && !fault_s && (mode_auto || !flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      act  <= 1'b0;
    end else begin
      flag <= detect || (flag && !flag_clr);
      if (detect)          act <= 1'b1;
      else if (release_ok) act <= 1'b0;
    end
  end
endmodule

// File: rtl/pfg_out_map.sv
module pfg_out_map
  import pfg_pkg::*;
(
  input  logic [NUM_PWM-1:0]   pwm_in,
  input  logic [NUM_PAIR-1:0]  pair_comp,
  input  logic [NUM_PAIR-1:0]  swap_en,
  input  logic [NUM_FAULT-1:0] act,
  input  mask_arr_t            dis_mask,
  output logic [NUM_PWM-1:0]   pwm_out
);
  logic [NUM_PWM-1:0] swapped;
  logic [NUM_PWM-1:0] kill;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic do_swap;
    assign do_swap        = swap_en[p] && pair_comp[p];
    assign swapped[2*p]   = do_swap ? pwm_in[2*p+1] : pwm_in[2*p];
    assign swapped[2*p+1] = do_swap ? pwm_in[2*p]   : pwm_in[2*p+1];
  end

  always_comb begin
    kill = '0;
    for (int i = 0; i < NUM_FAULT; i++) begin
      if (act[i]) kill = kill | dis_mask[i];
    end
  end

  assign pwm_out = swapped & ~kill;
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wen,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_PWM-1:0]   pwm_in,
  input  logic [NUM_PAIR-1:0]  pair_comp,
  input  logic                 period_edge,
  input  logic [NUM_FAULT-1:0] fault_in,
  output logic [NUM_PWM-1:0]   pwm_out,
  output logic [NUM_FAULT-1:0] fault_irq
);
  logic [NUM_FAULT-1:0] fault_s, fault_mode, fault_ie, fault_pe, fault_clr;
  logic [NUM_FAULT-1:0] fault_flag, fault_act;
  logic [NUM_PAIR-1:0]  swap_en;
  mask_arr_t            dis_mask;

  pfg_sync #(.WIDTH(NUM_FAULT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(fault_in), .q_sync(fault_s)
  );

  pfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .flag(fault_flag), .rdata(reg_rdata),
    .mode_auto(fault_mode), .irq_en(fault_ie), .pin_en(fault_pe),
    .flag_clr(fault_clr), .swap_en(swap_en), .dis_mask(dis_mask)
  );

  for (genvar i = 0; i < NUM_FAULT; i++) begin : g_chan
    pfg_fault_chan u_chan (
      .clk(clk), .rst_n(rst_n), .fault_s(fault_s[i]), .pin_en(fault_pe[i]),
      .mode_auto(fault_mode[i]), .flag_clr(fault_clr[i]),
      .period_edge(period_edge), .flag(fault_flag[i]), .act(fault_act[i])
    );
  end

  pfg_out_map u_map (
    .pwm_in(pwm_in), .pair_comp(pair_comp), .swap_en(swap_en),
    .act(fault_act), .dis_mask(dis_mask), .pwm_out(pwm_out)
  );

  assign fault_irq = fault_flag & fault_ie;
endmodule

// File: rtl/pfg_chk.sv
module pfg_chk
  import pfg_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wen,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [REG_W-1:0]     reg_rdata,
  input logic                 period_edge,
  input logic [NUM_PWM-1:0]   pwm_out,
  input logic [NUM_FAULT-1:0] fault_irq,
  input logic [NUM_FAULT-1:0] fault_act,
  input logic [NUM_FAULT-1:0] fault_flag,
  input logic [NUM_FAULT-1:0] fault_ie,
  input logic [NUM_FAULT-1:0] fault_mode,
  input mask_arr_t            dis_mask
);
  // R5
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq & ~fault_ie) == '0);

  // R3
  pin_odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_PINEN) |-> ((reg_rdata & 8'hAA) == 8'h00));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(fault_flag) & ~fault_flag)) |-> $past(reg_wen && (reg_addr == ADR_STAT)));

  // R8
  release_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(fault_act) & ~fault_act)) |-> $past(period_edge));

  // R7
  manual_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault_act) & ~fault_act & ~$past(fault_mode) & $past(fault_flag)) == '0);

  for (genvar i = 0; i < NUM_FAULT; i++) begin : g_gate
    // R4
    masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_act[i] |-> ((pwm_out & dis_mask[i]) == '0));
  end
endmodule

bind pwm_fault_guard pfg_chk u_chk (.*);

// File: tb/pwm_fault_guard_bench.sv
module pwm_fault_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wen = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] pwm_in = '0;
  logic [2:0] pair_comp = '0;
  logic       period_edge = 1'b0;
  logic [3:0] fault_in = '0;
  logic [5:0] pwm_out;
  logic [3:0] fault_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_fault_guard u_pwm_fault_guard (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clocks(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic edge_pulse();
    @(negedge clk); period_edge = 1'b1;
    @(negedge clk); period_edge = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    pwm_in = 6'b101101;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reg reset", d, 8'h00);
    end
    chk("R1 out passthrough", {2'b0, pwm_out}, 8'h2D);
    chk("R1 irq idle", {4'b0, fault_irq}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(3'd0, 8'hA5); rd(3'd0, d); chk("R2 ctrl readback", d, 8'hA5);
    wr(3'd5, 8'hFF); rd(3'd5, d); chk("R2 mask readback", d, 8'h3F);
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R3 pin odd bits zero", d, 8'h55);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd5, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    pwm_in = 6'b111111;
    wr(3'd4, 8'h3F);
    @(negedge clk); fault_in = 4'b0001;
    clocks(5);
    chk("R4 disabled fault no gating", {2'b0, pwm_out}, 8'h3F);
    rd(3'd2, d); chk("R4 disabled fault no flag", d, 8'h00);
    fault_in = 4'b0000;
    clocks(3);
  endtask

  task automatic t_manual();
    logic [7:0] d;
    pwm_in = 6'b111111;
    wr(3'd0, 8'h00); wr(3'd4, 8'h03); wr(3'd1, 8'h01);
    @(negedge clk); fault_in = 4'b0001;
    clocks(2);
    chk("R4 not yet gated after two edges", {2'b0, pwm_out}, 8'h3F);
    clocks(1);
    chk("R4 masked outputs low", {2'b0, pwm_out}, 8'h3C);
    chk("R5 no irq without enable", {4'b0, fault_irq}, 8'h00);
    rd(3'd2, d); chk("R6 flag set", d, 8'h01);
    wr(3'd2, 8'h01); rd(3'd2, d); chk("R6 clear ignored while high", d, 8'h01);
    fault_in = 4'b0000;
    clocks(3);
    edge_pulse();
    chk("R7 held while flag set", {2'b0, pwm_out}, 8'h3C);
    wr(3'd2, 8'h01); rd(3'd2, d); chk("R6 flag cleared", d, 8'h00);
    clocks(2);
    chk("R7 held until boundary", {2'b0, pwm_out}, 8'h3C);
    edge_pulse();
    chk("R7 released at boundary", {2'b0, pwm_out}, 8'h3F);
  endtask

  task automatic t_auto();
    logic [7:0] d;
    pwm_in = 6'b111111;
    wr(3'd0, 8'h0C); wr(3'd1, 8'h04); wr(3'd5, 8'h30);
    @(negedge clk); fault_in = 4'b0010;
    clocks(3);
    chk("R4 fault1 gating", {2'b0, pwm_out}, 8'h0F);
    chk("R5 irq with enable", {4'b0, fault_irq}, 8'h02);
    fault_in = 4'b0000;
    clocks(3);
    chk("R8 held before boundary", {2'b0, pwm_out}, 8'h0F);
    edge_pulse();
    chk("R8 auto release", {2'b0, pwm_out}, 8'h3F);
    rd(3'd2, d); chk("R8 flag remains", d, 8'h02);
    wr(3'd2, 8'h02);
    @(negedge clk);
    chk("R5 irq drops with flag", {4'b0, fault_irq}, 8'h00);
  endtask

  task automatic t_multi();
    pwm_in = 6'b111111;
    wr(3'd0, 8'hAA); wr(3'd1, 8'h55); wr(3'd6, 8'h04); wr(3'd7, 8'h20);
    @(negedge clk); fault_in = 4'b1100;
    clocks(3);
    chk("R9 union of masks", {2'b0, pwm_out}, 8'h1B);
    fault_in = 4'b0100;
    clocks(3);
    edge_pulse();
    chk("R9 one fault released", {2'b0, pwm_out}, 8'h3B);
    fault_in = 4'b0000;
    clocks(3);
    edge_pulse();
    chk("R9 all released", {2'b0, pwm_out}, 8'h3F);
    wr(3'd2, 8'h0F); wr(3'd1, 8'h00);
  endtask

  task automatic t_swap();
    logic [7:0] d;
    pwm_in = 6'b000001; pair_comp = 3'b111;
    wr(3'd3, 8'h07); rd(3'd3, d); chk("R11 swap locked", d, 8'h00);
    chk("R11 locked no swap", {2'b0, pwm_out}, 8'h01);
    wr(3'd3, 8'h87); rd(3'd3, d); chk("R11 enable write keeps swap", d, 8'h80);
    wr(3'd3, 8'h87); rd(3'd3, d); chk("R11 swap written", d, 8'h87);
    chk("R10 pair0 swapped", {2'b0, pwm_out}, 8'h02);
    pwm_in = 6'b010100; #1;
    chk("R10 all pairs swapped", {2'b0, pwm_out}, 8'h28);
    pair_comp = 3'b000; #1;
    chk("R10 no swap when not complementary", {2'b0, pwm_out}, 8'h14);
    pair_comp = 3'b010; #1;
    chk("R10 only pair1 swapped", {2'b0, pwm_out}, 8'h18);
  endtask

  task automatic t_swap_gate();
    pwm_in = 6'b000001; pair_comp = 3'b001;
    wr(3'd0, 8'h02); wr(3'd1, 8'h01); wr(3'd4, 8'h02);
    @(negedge clk); fault_in = 4'b0001;
    clocks(3);
    chk("R12 mask after swap", {2'b0, pwm_out}, 8'h00);
    fault_in = 4'b0000;
    clocks(3);
    edge_pulse();
    chk("R12 released after swap", {2'b0, pwm_out}, 8'h02);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #40000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    clocks(3);
    rst_n = 1'b1;
    clocks(2);
    t_reset();
    t_regs();
    t_disabled();
    t_manual();
    t_auto();
    t_multi();
    t_swap();
    t_swap_gate();
    finish_run();
  end
endmodule